// File: doc/BRIEF.md
# Pipelined Vector Element Multiply Unit

The unit holds a small file of vector registers and executes one element-wise multiply instruction at a time. An instruction names two source registers, one destination register and a vector length n. Element pairs leave the sources in ascending index order, one pair per clock, and pass through an m-stage pipelined integer multiplier. Each stage adds one slice of partial products. Each product is written to the same index of the destination register as it leaves the final stage.

A controller sequences the instruction with four named states. IDLE waits for work. ISSUE sends one element pair per cycle into the pipeline. DRAIN waits for the pipeline to empty. FIN raises the completion pulse for one cycle. The transitions are as follows. IDLE or FIN goes to ISSUE on an accepted start with n > 0, and goes to FIN on an accepted start with n = 0. Without a start, both go to IDLE. ISSUE stays in ISSUE while pairs remain. ISSUE goes to DRAIN after the last pair is issued, or goes straight to FIN if that last pair is already at the final stage. DRAIN goes to FIN when the last pair reaches the final stage. The unit is busy in ISSUE and DRAIN and accepts nothing new until the pipeline has drained. A separate element port loads and reads the registers. A cycle counter reports how long the last instruction took.

Top module: `vmul_unit`

## Requirements
- R1: After reset, busy, done and start_err are 0, cycle_count is 0, and every register element reads 0.
- R2: A write with wr_en high while busy is low stores wr_data into element wr_idx (0-based) of register wr_sel. rd_data shows element rd_idx of register rd_sel combinationally. A write while busy is high is ignored.
- R3: For i = 0..n-1 the destination element i becomes (a[i] * b[i]) mod 2^DATA_W, unsigned. Destination elements at index n and above are unchanged. A source may be the same register as the destination or as the other source. Results are written one per cycle in ascending index order.
- R4: A start sampled high at a rising edge while busy is low is accepted. With n > 0, busy is high for exactly n+STAGES-1 cycles beginning the next cycle. done is high for the single cycle right after busy falls.
- R5: While done is high, cycle_count equals n+STAGES-1. It holds that value until the next accepted start.
- R6: An accepted start with n = 0 never raises busy. It raises done in the next cycle with cycle_count 0 and writes nothing.
- R7: A start while busy is ignored and the running instruction continues unchanged. start_err is high for one cycle in the cycle after that edge.
- R8: A start_len above DEPTH is treated as DEPTH.
- R9: A start in the cycle in which done is high is accepted.
- R10: With STAGES = 1 and n = 1 the unit acts as a scalar multiplier: busy for one cycle, then done with cycle_count 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction request strobe |
| start_len | input | LEN_W | Vector length n |
| start_src_a | input | SEL_W | First source register |
| start_src_b | input | SEL_W | Second source register |
| start_dst | input | SEL_W | Destination register |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| start_err | output | 1 | Start was rejected while busy |
| cycle_count | output | CNT_W | Cycles of the last instruction |
| wr_en | input | 1 | Element write enable |
| wr_sel | input | SEL_W | Register to write |
| wr_idx | input | IDX_W | Element index to write |
| wr_data | input | DATA_W | Element write data |
| rd_sel | input | SEL_W | Register to read |
| rd_idx | input | IDX_W | Element index to read |
| rd_data | output | DATA_W | Element read data |

## Verification
A full-length vector with operands that include all-ones values exercises the wrap of the product modulo the word width and the carries across partial-product slices. A vector shorter than the pipeline depth shows that valid bits, not pipeline fill, decide the write-backs and the drain time. An in-place squaring instruction shows that each source element is read before its index is overwritten. An over-long length, a zero length, a start while busy and a start in the done cycle separate clamping, the immediate-completion path, rejection and back-to-back acceptance. The read port is swept during execution, so out-of-order or early writes show up in the cycle they occur.

// File: rtl/vmul_pkg.sv
package vmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FIN   = 2'd3
    } vmul_state_e;

endpackage

// File: rtl/vmul_regfile.sv
module vmul_regfile #(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 8,
    parameter int NUM_REGS = 4,
    parameter int NUM_RD   = 3,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  w_sel,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [SEL_W-1:0]  rd_sel  [NUM_RD],
    input  logic [IDX_W-1:0]  rd_idx  [NUM_RD],
    output logic [DATA_W-1:0] rd_data [NUM_RD]
);

    logic [DATA_W-1:0] mem [NUM_REGS][DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                for (int e = 0; e < DEPTH; e++) begin
                    mem[r][e] <= '0;
                end
            end
        end else if (we && int'(w_idx) < DEPTH && int'(w_sel) < NUM_REGS) begin
            mem[w_sel][w_idx] <= w_data;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            if (int'(rd_idx[p]) < DEPTH && int'(rd_sel[p]) < NUM_REGS) begin
                rd_data[p] = mem[rd_sel[p]][rd_idx[p]];
            end else begin
                rd_data[p] = '0;
            end
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(w_idx) < DEPTH)); // R2

endmodule

// File: rtl/vmul_pp_stage.sv
module vmul_pp_stage #(
    parameter int DATA_W    = 16,
    parameter int STAGES    = 3,
    parameter int STAGE_IDX = 0,
    localparam int SLICE_W  = (DATA_W + STAGES - 1) / STAGES,
    localparam int SHIFT    = STAGE_IDX * SLICE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] acc_in,
    output logic [DATA_W-1:0] acc_out
);

    localparam logic [DATA_W-1:0] SLICE_MASK = {DATA_W{1'b1}} >> (DATA_W - SLICE_W);

    logic [DATA_W-1:0] b_slice;
    logic [DATA_W-1:0] part;

    always_comb begin
        b_slice = (b >> SHIFT) & SLICE_MASK;
        part    = a * b_slice;
        acc_out = acc_in + (part << SHIFT);
    end

endmodule

// File: rtl/vmul_ctrl.sv
module vmul_ctrl
    import vmul_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int NUM_REGS = 4,
    parameter int STAGES   = 3,
    localparam int LEN_W   = $clog2(DEPTH + 1),
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(DEPTH + STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] start_len,
    input  logic [SEL_W-1:0] start_src_a,
    input  logic [SEL_W-1:0] start_src_b,
    input  logic [SEL_W-1:0] start_dst,
    input  logic             fin_fire,
    output logic             busy,
    output logic             done,
    output logic             start_err,
    output logic             issue_vld,
    output logic [IDX_W-1:0] issue_idx,
    output logic             issue_last,
    output logic [SEL_W-1:0] src_a_q,
    output logic [SEL_W-1:0] src_b_q,
    output logic [SEL_W-1:0] dst_q,
    output logic [CNT_W-1:0] cycle_count
);

    vmul_state_e      state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_eff;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             accept;
    logic             can_take;

    assign can_take = (state_q == ST_IDLE) || (state_q == ST_FIN);
    assign accept   = start && can_take;
    assign len_eff  = (start_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : start_len;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (accept) begin
                    state_d = (len_eff == '0) ? ST_FIN : ST_ISSUE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ISSUE: begin
                if (fin_fire) begin
                    state_d = ST_FIN;
                end else if (issue_last) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (fin_fire) begin
                    state_d = ST_FIN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            src_a_q <= '0;
            src_b_q <= '0;
            dst_q   <= '0;
        end else begin
            err_q <= start && busy;
            if (accept) begin
                len_q   <= len_eff;
                src_a_q <= start_src_a;
                src_b_q <= start_src_b;
                dst_q   <= start_dst;
                idx_q   <= '0;
                cnt_q   <= '0;
            end else begin
                if (state_q == ST_ISSUE) begin
                    idx_q <= idx_q + 1'b1;
                end
                if (busy) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        issue_vld   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                busy      = 1'b1;
                issue_vld = 1'b1;
            end
            ST_DRAIN: busy = 1'b1;
            ST_FIN:   done = 1'b1;
            default:  ;
        endcase
        issue_idx   = idx_q;
        issue_last  = issue_vld && (LEN_W'(idx_q) == len_q - LEN_W'(1));
        start_err   = err_q;
        cycle_count = cnt_q;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R4
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R4
    AST_CYCLES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(busy)) |-> (cycle_count == CNT_W'(len_q) + CNT_W'(STAGES - 1))); // R5
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(busy)) |-> (cycle_count == '0)); // R6
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dst_q) && $stable(len_q) && start_err)); // R7
    AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (len_q <= LEN_W'(DEPTH))); // R8

endmodule

// File: rtl/vmul_unit.sv
module vmul_unit #(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 8,
    parameter int NUM_REGS = 4,
    parameter int STAGES   = 3,
    localparam int LEN_W   = $clog2(DEPTH + 1),
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(DEPTH + STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [SEL_W-1:0]  start_src_a,
    input  logic [SEL_W-1:0]  start_src_b,
    input  logic [SEL_W-1:0]  start_dst,
    output logic              busy,
    output logic              done,
    output logic              start_err,
    output logic [CNT_W-1:0]  cycle_count,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              valid;
        logic              last;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] acc;
    } stage_t;

    logic             issue_vld;
    logic [IDX_W-1:0] issue_idx;
    logic             issue_last;
    logic [SEL_W-1:0] src_a_q, src_b_q, dst_q;
    logic             fin_fire;

    logic [SEL_W-1:0]  rf_rd_sel  [3];
    logic [IDX_W-1:0]  rf_rd_idx  [3];
    logic [DATA_W-1:0] rf_rd_data [3];
    logic              rf_we;
    logic [SEL_W-1:0]  rf_w_sel;
    logic [IDX_W-1:0]  rf_w_idx;
    logic [DATA_W-1:0] rf_w_data;

    stage_t            issue_pkt;
    stage_t            st_in   [STAGES];
    logic [DATA_W-1:0] acc_out [STAGES];
    stage_t            fin;

    vmul_ctrl #(
        .DEPTH    (DEPTH),
        .NUM_REGS (NUM_REGS),
        .STAGES   (STAGES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_len   (start_len),
        .start_src_a (start_src_a),
        .start_src_b (start_src_b),
        .start_dst   (start_dst),
        .fin_fire    (fin_fire),
        .busy        (busy),
        .done        (done),
        .start_err   (start_err),
        .issue_vld   (issue_vld),
        .issue_idx   (issue_idx),
        .issue_last  (issue_last),
        .src_a_q     (src_a_q),
        .src_b_q     (src_b_q),
        .dst_q       (dst_q),
        .cycle_count (cycle_count)
    );

    assign rf_rd_sel[0] = src_a_q;
    assign rf_rd_idx[0] = issue_idx;
    assign rf_rd_sel[1] = src_b_q;
    assign rf_rd_idx[1] = issue_idx;
    assign rf_rd_sel[2] = rd_sel;
    assign rf_rd_idx[2] = rd_idx;
    assign rd_data      = rf_rd_data[2];

    vmul_regfile #(
        .DATA_W   (DATA_W),
        .DEPTH    (DEPTH),
        .NUM_REGS (NUM_REGS),
        .NUM_RD   (3)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .w_sel   (rf_w_sel),
        .w_idx   (rf_w_idx),
        .w_data  (rf_w_data),
        .rd_sel  (rf_rd_sel),
        .rd_idx  (rf_rd_idx),
        .rd_data (rf_rd_data)
    );

    always_comb begin
        issue_pkt.valid = issue_vld;
        issue_pkt.last  = issue_last;
        issue_pkt.idx   = issue_idx;
        issue_pkt.a     = rf_rd_data[0];
        issue_pkt.b     = rf_rd_data[1];
        issue_pkt.acc   = '0;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        vmul_pp_stage #(
            .DATA_W    (DATA_W),
            .STAGES    (STAGES),
            .STAGE_IDX (s)
        ) u_pp (
            .a       (st_in[s].a),
            .b       (st_in[s].b),
            .acc_in  (st_in[s].acc),
            .acc_out (acc_out[s])
        );

        if (s == 0) begin : g_head
            assign st_in[0] = issue_pkt;
        end else begin : g_reg
            stage_t pipe_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q     <= st_in[s-1];
                    pipe_q.acc <= acc_out[s-1];
                end
            end
            assign st_in[s] = pipe_q;
        end
    end

    assign fin      = st_in[STAGES-1];
    assign fin_fire = fin.valid && fin.last;

    always_comb begin
        if (fin.valid) begin
            rf_we     = 1'b1;
            rf_w_sel  = dst_q;
            rf_w_idx  = fin.idx;
            rf_w_data = acc_out[STAGES-1];
        end else begin
            rf_we     = wr_en && !busy;
            rf_w_sel  = wr_sel;
            rf_w_idx  = wr_idx;
            rf_w_data = wr_data;
        end
    end

    AST_WB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fin.valid |-> busy); // R3
    AST_WB_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (fin.valid && fin.idx != '0) |-> ($past(fin.valid) && ($past(fin.idx) == fin.idx - IDX_W'(1)))); // R3
    AST_NO_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> !fin.valid); // R6

endmodule

// File: tb/vmul_unit_tb_top.sv
module vmul_unit_tb_top;

    localparam int DW  = 16;
    localparam int DEP = 8;
    localparam int NR  = 4;
    localparam int M   = 3;
    localparam int LW  = $clog2(DEP + 1);
    localparam int IW  = $clog2(DEP);
    localparam int SW  = $clog2(NR);
    localparam int CW  = $clog2(DEP + M);
    localparam int CW1 = $clog2(DEP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] start_len = '0;
    logic [SW-1:0] start_src_a = '0, start_src_b = '0, start_dst = '0;
    logic          busy, done, start_err;
    logic [CW-1:0] cycle_count;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_sel = '0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [SW-1:0] rd_sel = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [DW-1:0] rd_data;

    logic           s1_start = 1'b0;
    logic [LW-1:0]  s1_len = '0;
    logic           s1_busy, s1_done, s1_err;
    logic [CW1-1:0] s1_count;
    logic           s1_wr_en = 1'b0;
    logic [SW-1:0]  s1_wr_sel = '0;
    logic [IW-1:0]  s1_wr_idx = '0;
    logic [DW-1:0]  s1_wr_data = '0;
    logic [SW-1:0]  s1_rd_sel = '0;
    logic [DW-1:0]  s1_rd_data;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;

    always #5 clk = ~clk;

    vmul_unit #(.DATA_W(DW), .DEPTH(DEP), .NUM_REGS(NR), .STAGES(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .start_src_a(start_src_a), .start_src_b(start_src_b), .start_dst(start_dst),
        .busy(busy), .done(done), .start_err(start_err), .cycle_count(cycle_count),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    vmul_unit #(.DATA_W(DW), .DEPTH(DEP), .NUM_REGS(NR), .STAGES(1)) dut_s1 (
        .clk(clk), .rst_n(rst_n), .start(s1_start), .start_len(s1_len),
        .start_src_a(2'd0), .start_src_b(2'd1), .start_dst(2'd2),
        .busy(s1_busy), .done(s1_done), .start_err(s1_err), .cycle_count(s1_count),
        .wr_en(s1_wr_en), .wr_sel(s1_wr_sel), .wr_idx(s1_wr_idx), .wr_data(s1_wr_data),
        .rd_sel(s1_rd_sel), .rd_idx(3'd0), .rd_data(s1_rd_data)
    );

    // behavioural reference model
    longint mm [NR][DEP];
    bit     m_busy, m_done, m_err;
    int     m_step, m_len, m_a, m_b, m_d, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NR; r++)
                for (int e = 0; e < DEP; e++) mm[r][e] = 0;
            m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0; m_step = 0; m_len = 0;
        end else begin
            m_err = start && m_busy;
            if (m_busy) begin
                m_step++;
                m_cnt++;
                if (m_step - M >= 0 && m_step - M < m_len)
                    mm[m_d][m_step - M] = (mm[m_a][m_step - M] * mm[m_b][m_step - M]) & 64'hFFFF;
                if (m_step == m_len + M - 1) begin
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    m_done = 0;
                end
            end else begin
                m_done = 0;
                if (wr_en) mm[wr_sel][wr_idx] = wr_data;
                if (start) begin
                    m_len  = (int'(start_len) > DEP) ? DEP : int'(start_len);
                    m_a    = start_src_a;
                    m_b    = start_src_b;
                    m_d    = start_dst;
                    m_cnt  = 0;
                    m_step = 0;
                    if (m_len == 0) m_done = 1;
                    else m_busy = 1;
                end
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            chk("R4 busy", busy, m_busy);
            chk("R4 done", done, m_done);
            chk("R7 start_err", start_err, m_err);
            chk("R5 cycle_count", cycle_count, m_cnt);
            chk("R3 rd_data", rd_data, mm[rd_sel][rd_idx]);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(int sel, int idx, int data);
        wr_en = 1'b1; wr_sel = SW'(sel); wr_idx = IW'(idx); wr_data = DW'(data);
        step();
        wr_en = 1'b0;
    endtask

    task automatic issue(int len, int a, int b, int d);
        start = 1'b1; start_len = LW'(len);
        start_src_a = SW'(a); start_src_b = SW'(b); start_dst = SW'(d);
        step();
        start = 1'b0;
    endtask

    task automatic run(int len, int a, int b, int d, output int nbusy);
        issue(len, a, b, d);
        nbusy = 0;
        while (m_busy) begin
            nbusy++;
            rd_sel = SW'(d);
            rd_idx = rd_idx + 1'b1;
            step();
        end
    endtask

    task automatic peek(int sel, int idx, string tag, longint exp);
        rd_sel = SW'(sel); rd_idx = IW'(idx);
        #1;
        chk(tag, rd_data, exp);
    endtask

    longint av [DEP];
    longint bv [DEP];
    longint sq [DEP];

    initial begin
        int nb;
        for (int i = 0; i < DEP; i++) begin
            av[i] = (64'h1111 * (i + 1)) & 64'hFFFF;
            bv[i] = (64'h0F0F + 64'd37 * i) & 64'hFFFF;
        end
        av[DEP-1] = 64'hFFFF;
        bv[DEP-1] = 64'hFFFF;

        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        step();
        chk_en = 1'b1;

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 start_err", start_err, 0);
        chk("R1 cycle_count", cycle_count, 0);
        peek(2, 5, "R1 element", 0);
        peek(3, 0, "R1 element", 0);

        // R2 load sources and read back
        for (int i = 0; i < DEP; i++) begin
            wr(0, i, int'(av[i]));
            wr(1, i, int'(bv[i]));
        end
        peek(0, 3, "R2 readback", av[3]);
        peek(1, 7, "R2 readback", bv[7]);

        // R3/R4/R5 full length
        run(8, 0, 1, 2, nb);
        chk("R4 busy cycles n=8", nb, 8 + M - 1);
        chk("R4 done after drain", done, 1);
        chk("R5 count n=8", cycle_count, 8 + M - 1);
        for (int i = 0; i < DEP; i++)
            peek(2, i, "R3 product", (av[i] * bv[i]) & 64'hFFFF);
        peek(2, 7, "R3 wrap all-ones", 1);

        // R3 n < m, untouched tail
        run(2, 0, 1, 3, nb);
        chk("R5 count n=2", cycle_count, 2 + M - 1);
        peek(3, 1, "R3 short product", (av[1] * bv[1]) & 64'hFFFF);
        peek(3, 2, "R3 tail untouched", 0);
        peek(3, 7, "R3 tail untouched", 0);

        // R3 in-place squaring, back-to-back start in done cycle (R9)
        for (int i = 0; i < DEP; i++) sq[i] = ((av[i] * bv[i]) & 64'hFFFF);
        issue(4, 2, 2, 2);
        chk("R9 accepted in done cycle", busy, 1);
        while (m_busy) step();
        for (int i = 0; i < 4; i++)
            peek(2, i, "R3 in-place square", (sq[i] * sq[i]) & 64'hFFFF);
        peek(2, 5, "R3 in-place tail", sq[5]);

        // R6 zero length
        step();
        issue(0, 0, 1, 3);
        chk("R6 done next cycle", done, 1);
        chk("R6 never busy", busy, 0);
        chk("R6 count zero", cycle_count, 0);
        peek(3, 0, "R6 no write", (av[0] * bv[0]) & 64'hFFFF);
        step();

        // R7 start while busy, R2 write while busy
        issue(8, 1, 0, 3);
        start = 1'b1; start_len = LW'(1); start_dst = SW'(1);
        step();
        start = 1'b0;
        chk("R7 start_err pulse", start_err, 1);
        wr(0, 0, 16'hDEAD);
        chk("R7 start_err one cycle", start_err, 0);
        while (m_busy) step();
        chk("R7 count unaffected", cycle_count, 8 + M - 1);
        peek(0, 0, "R2 write while busy ignored", av[0]);
        peek(1, 0, "R7 rejected dst untouched", bv[0]);
        peek(3, 6, "R7 original runs", (av[6] * bv[6]) & 64'hFFFF);

        // R8 over-long length
        step();
        run(12, 0, 0, 3, nb);
        chk("R8 clamped busy", nb, DEP + M - 1);
        chk("R8 clamped count", cycle_count, DEP + M - 1);
        peek(3, 7, "R8 last element", 1);
        peek(3, 2, "R8 square", (av[2] * av[2]) & 64'hFFFF);
        step();

        // R10 single-stage scalar
        chk_en = 1'b0;
        s1_wr_en = 1'b1; s1_wr_sel = 2'd0; s1_wr_idx = 3'd0; s1_wr_data = 16'd7;
        step();
        s1_wr_sel = 2'd1; s1_wr_data = 16'd9;
        step();
        s1_wr_en = 1'b0;
        s1_start = 1'b1; s1_len = LW'(1);
        step();
        s1_start = 1'b0;
        chk("R10 busy one cycle", s1_busy, 1);
        step();
        chk("R10 busy fell", s1_busy, 0);
        chk("R10 done", s1_done, 1);
        chk("R10 count", s1_count, 1);
        s1_rd_sel = 2'd2;
        #1;
        chk("R10 product", s1_rd_data, 63);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule